// File: doc/BRIEF.md
# Four-Pin GPIO Port with Change Interrupt

This block is the general-purpose I/O section of a serial peripheral. It has four pins. Each pin is set to input or output by its own direction bit. A byte-wide register bus reaches the block through a 2-bit address, a write strobe and a read strobe. The bus reaches four registers: direction, pin state, interrupt enable and control. The state register drives the output pins when written. When read, it returns the pin levels.

Each input is synchronised through two flops. The synchronised level is then compared with a per-pin reference. When an enabled input differs from its reference, the block raises one shared interrupt. A read of the state register acknowledges the interrupt.

The control register selects between two modes:
- **Transparent mode:** the interrupt falls on its own if the pin returns to its old level before the acknowledge.
- **Capture mode:** the interrupt and the captured pin value are held until the acknowledge.

The control register also holds a plain modem-pin enable bit and a self-clearing soft-reset bit. The soft-reset bit emits a one-cycle pulse and returns every register to zero.

Top module: `gpio_chg_port`

## Requirements
- R1: After rst_n is held low, the direction, enable and control registers read 0, pin_oe is 0, irq is 0 and sw_rst_pulse is 0.
- R2: Address 0 is the direction register. Bit i = 1 makes pin i an output, and pin_oe follows the register. Bits [3:0] read back as written, and bits [7:4] read 0.
- R3: Address 1 is the state register. A write sets pin_out to wdata[3:0]. A read returns the written level for output pins and the synchronised pin level for input pins, after two clocks of latency. Bits [7:4] read 0.
- R4: Address 2 is the interrupt-enable register (bit i for pin i). A level change on a pin that is disabled, or that is an output, never raises irq.
- R5: With control bit 0 = 0 (transparent mode), irq is high while any enabled input differs from its reference. A read of the state register reloads the references from the pins, which drops irq.
- R6: In transparent mode, if an enabled input returns to its reference level before a state read, irq falls again without any read.
- R7: With control bit 0 = 1 (capture mode), an enabled input change sets irq and loads the new level into that pin's state bit. Both persist after the pin reverts.
- R8: In capture mode, a state read returns the captured value and clears irq. Later reads show the live pin level.
- R9: Control bit 1 is a plain read/write bit that drives modem_en. Control bits 2 and [7:4] read 0.
- R10: Writing the control register with bit 3 = 1 gives exactly one cycle of sw_rst_pulse on the next clock. The pulse returns every register to 0, and control bit 3 reads 0 afterwards.
- R11: While a pin is disabled or an output, its reference follows the pin. Enabling a pin that already sits high therefore does not raise irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register select: 0 direction, 1 state, 2 enable, 3 control |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; a read of address 1 acknowledges the interrupt |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| pin_in | input | 4 | Pin levels from the pads (asynchronous) |
| pin_out | output | 4 | Output levels written through the state register |
| pin_oe | output | 4 | Output enable per pin (direction register) |
| irq | output | 1 | Change interrupt |
| modem_en | output | 1 | Modem-pin function enable (control bit 1) |
| sw_rst_pulse | output | 1 | One-cycle soft-reset pulse |

## Verification
A constrained-random loop sets random direction, output and pin patterns and compares each state read with a bench model. This separates the output-pin path from the synchronised input-pin path.

A second random loop flips random pin subsets under random enable masks. It shows whether irq depends on the enabled input pins alone, and whether the acknowledge drops it.

Directed cases cover the following:
- a pulse that reverts before the read, run in each mode; this tells transparent behaviour from capture behaviour;
- enabling a pin that already sits high;
- toggling pins while they are outputs;
- soft reset with every register loaded.

// File: rtl/gpio_port_pkg.sv
// Package: register addresses and control-bit positions shared by the GPIO port.
package gpio_port_pkg;
    localparam logic [1:0] ADDR_DIR   = 2'd0;
    localparam logic [1:0] ADDR_STATE = 2'd1;
    localparam logic [1:0] ADDR_IEN   = 2'd2;
    localparam logic [1:0] ADDR_CTRL  = 2'd3;

    localparam int CTRL_LATCH = 0;
    localparam int CTRL_MODEM = 1;
    localparam int CTRL_SWRST = 3;
endpackage

// File: rtl/gpio_sync.sv
// gpio_sync: multi-stage level synchroniser for W asynchronous inputs.
// Assumes inputs are quasi-static relative to clk; adds STAGES cycles of latency.
module gpio_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the pin levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// gpio_regs: direction, output, enable and control registers with soft reset.
// Assumes one-cycle write strobes; a control write with the reset bit set
// only arms the pulse, which clears all registers on the following edge.
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int W  = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  out_q,
    output logic [W-1:0]  ien_q,
    output logic          latch_mode,
    output logic          modem_en,
    output logic          swrst
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DW-1:W];

    // Register writes; hard reset and the soft-reset pulse both clear everything.
    always_ff @(posedge clk) begin
        if (!rst_n || swrst) begin
            dir_q      <= '0;
            out_q      <= '0;
            ien_q      <= '0;
            latch_mode <= 1'b0;
            modem_en   <= 1'b0;
            swrst      <= 1'b0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_DIR:   dir_q <= wdata[W-1:0];
                ADDR_STATE: out_q <= wdata[W-1:0];
                ADDR_IEN:   ien_q <= wdata[W-1:0];
                ADDR_CTRL: begin
                    if (wdata[CTRL_SWRST]) begin
                        swrst <= 1'b1;
                    end else begin
                        latch_mode <= wdata[CTRL_LATCH];
                        modem_en   <= wdata[CTRL_MODEM];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_chg_detect.sv
// gpio_chg_detect: per-pin change detection against a reference, with an
// optional capture of the level that caused the change.
// Assumes pin_s is already synchronised; state_rd is the acknowledge strobe.
module gpio_chg_detect #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] pin_s,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] ien_q,
    input  logic         latch_mode,
    input  logic         state_rd,
    output logic [W-1:0] in_view,
    output logic         irq
);
    logic [W-1:0] pend;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic ref_q, cap_pend, cap_val;
        logic watch, live;

        assign watch = ien_q[i] & ~dir_q[i];
        assign live  = watch & (pin_s[i] ^ ref_q);

        // Reference tracking and capture state for one pin.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                ref_q    <= 1'b0;
                cap_pend <= 1'b0;
                cap_val  <= 1'b0;
            end else begin
                if (state_rd || !watch) ref_q <= pin_s[i];
                if (state_rd || !latch_mode || !watch) begin
                    cap_pend <= 1'b0;
                end else if (live && !cap_pend) begin
                    cap_pend <= 1'b1;
                    cap_val  <= pin_s[i];
                end
            end
        end

        assign in_view[i] = cap_pend ? cap_val : pin_s[i];
        assign pend[i]    = latch_mode ? cap_pend : live;
    end

    assign irq = |pend;
endmodule

// File: rtl/gpio_chg_port.sv
// gpio_chg_port: four-pin GPIO port with register bus and change interrupt.
// Assumes one-cycle read/write strobes; rdata is combinational on addr.
module gpio_chg_port
    import gpio_port_pkg::*;
#(
    parameter int W      = 4,
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic          irq,
    output logic          modem_en,
    output logic          sw_rst_pulse
);
    logic [W-1:0] pin_s, dir_q, out_q, ien_q, in_view;
    logic         latch_mode, swrst, state_rd;

    assign state_rd = rd_en && (addr == ADDR_STATE);

    gpio_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
    );

    gpio_regs #(.W(W), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .dir_q(dir_q), .out_q(out_q), .ien_q(ien_q),
        .latch_mode(latch_mode), .modem_en(modem_en), .swrst(swrst)
    );

    gpio_chg_detect #(.W(W)) u_det (
        .clk(clk), .rst_n(rst_n), .clr(swrst), .pin_s(pin_s),
        .dir_q(dir_q), .ien_q(ien_q), .latch_mode(latch_mode),
        .state_rd(state_rd), .in_view(in_view), .irq(irq)
    );

    // Read-data multiplexer, unused upper bits forced to zero.
    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_DIR:   rdata[W-1:0] = dir_q;
            ADDR_STATE: rdata[W-1:0] = (dir_q & out_q) | (~dir_q & in_view);
            ADDR_IEN:   rdata[W-1:0] = ien_q;
            ADDR_CTRL: begin
                rdata[CTRL_LATCH] = latch_mode;
                rdata[CTRL_MODEM] = modem_en;
                rdata[CTRL_SWRST] = swrst;
            end
            default: ;
        endcase
    end

    assign pin_out      = out_q;
    assign pin_oe       = dir_q;
    assign sw_rst_pulse = swrst;
endmodule

// File: rtl/gpio_chg_port_chk.sv
// gpio_chg_port_chk: temporal checks on the GPIO port, bound to the top module.
module gpio_chg_port_chk
    import gpio_port_pkg::*;
#(
    parameter int W  = 4,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] wdata,
    input logic          irq,
    input logic          sw_rst_pulse,
    input logic [W-1:0]  pin_oe,
    input logic          modem_en,
    input logic          latch_mode,
    input logic [W-1:0]  pin_s
);
    // R10: pulse lasts one cycle.
    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_pulse |=> !sw_rst_pulse);

    // R10: pulse only follows a control write with the reset bit.
    assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_rst_pulse) |-> $past(wr_en && addr == ADDR_CTRL && wdata[CTRL_SWRST]));

    // R10: registers cleared after the pulse.
    assert_pulse_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_pulse |=> (pin_oe == '0 && !modem_en && !irq));

    // R4: all-output port in transparent mode never interrupts.
    assert_outputs_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe == {W{1'b1}} && !latch_mode) |-> !irq);

    // R5/R8: acknowledge clears irq unless the pins moved again.
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == ADDR_STATE) |=> (!irq || pin_s != $past(pin_s)));

    // R7: a captured interrupt persists without acknowledge or reconfiguration.
    assert_capture_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && irq && !rd_en && !wr_en && !sw_rst_pulse) |=> irq);
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.W(W), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .irq(irq), .sw_rst_pulse(sw_rst_pulse), .pin_oe(pin_oe),
    .modem_en(modem_en), .latch_mode(latch_mode), .pin_s(pin_s)
);

// File: tb/gpio_chg_port_tb.sv
// gpio_chg_port_tb: seeded random plus directed checks of the GPIO port.
module gpio_chg_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] pin_in = '0;
    logic [3:0] pin_out, pin_oe;
    logic       irq, modem_en, sw_rst_pulse;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_chg_port u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq), .modem_en(modem_en), .sw_rst_pulse(sw_rst_pulse)
    );

    // Expected state read: outputs show written level, inputs show pins.
    function automatic logic [7:0] exp_state(logic [3:0] d, logic [3:0] o, logic [3:0] p);
        return {4'b0, (d & o) | (~d & p)};
    endfunction

    // Expected transparent-mode irq from a pin flip.
    function automatic logic exp_irq(logic [3:0] d, logic [3:0] en, logic [3:0] a, logic [3:0] b);
        return |((a ^ b) & en & ~d);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 dir", v, 8'h00);
        rd(2'd2, v); chk("R1 ien", v, 8'h00);
        rd(2'd3, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 oe/irq/pulse", {pin_oe, irq, sw_rst_pulse}, 6'h00);

        // R2 direction register
        wr(2'd0, 8'hA5); rd(2'd0, v);
        chk("R2 dir readback", v, 8'h05);
        chk("R2 pin_oe", pin_oe, 4'h5);

        // R3 random state read/write patterns
        for (int k = 0; k < 24; k++) begin
            logic [3:0] d, o, p;
            d = 4'($urandom); o = 4'($urandom); p = 4'($urandom);
            wr(2'd0, {4'hF, d}); wr(2'd1, {4'hF, o});
            pin_in = p; settle();
            chk("R3 pin_out", pin_out, o);
            rd(2'd1, v); chk("R3 state read", v, exp_state(d, o, p));
        end

        // R4 disabled inputs and output pins stay quiet
        wr(2'd0, 8'h00); wr(2'd2, 8'h00); pin_in = 4'h0; settle(); rd(2'd1, v);
        pin_in = 4'hF; settle(); chk("R4 disabled no irq", irq, 1'b0);
        wr(2'd0, 8'h0F); wr(2'd2, 8'h0F);
        pin_in = 4'h0; settle(); chk("R4 outputs no irq", irq, 1'b0);

        // R11 enabling a pin that already sits high
        wr(2'd2, 8'h00); wr(2'd0, 8'h00); pin_in = 4'hF; settle();
        wr(2'd2, 8'h0F); settle(); chk("R11 enable high pin", irq, 1'b0);

        // R5 random flips under random enable masks, transparent mode
        for (int k = 0; k < 24; k++) begin
            logic [3:0] en, a, b;
            en = 4'($urandom); a = 4'($urandom); b = 4'($urandom);
            wr(2'd2, 8'h00); pin_in = a; settle();
            wr(2'd2, {4'h0, en}); rd(2'd1, v);
            pin_in = b; settle();
            chk("R5 irq on change", irq, exp_irq(4'h0, en, a, b));
            rd(2'd1, v); chk("R5 read value", v, {4'h0, b});
            @(negedge clk); chk("R5 ack clears", irq, 1'b0);
        end

        // R6 transparent revert withdraws irq
        wr(2'd2, 8'h00); pin_in = 4'h0; settle(); wr(2'd2, 8'h01); rd(2'd1, v);
        pin_in = 4'h1; settle(); chk("R6 irq raised", irq, 1'b1);
        pin_in = 4'h0; settle(); chk("R6 revert withdraws", irq, 1'b0);

        // R7 capture mode holds irq and value after revert
        wr(2'd3, 8'h01); wr(2'd2, 8'h04); rd(2'd1, v);
        pin_in = 4'h4; settle(); chk("R7 irq raised", irq, 1'b1);
        pin_in = 4'h0; settle(); chk("R7 irq held", irq, 1'b1);
        // R8 read returns captured value and clears
        rd(2'd1, v); chk("R8 captured value", v, 8'h04);
        @(negedge clk); chk("R8 irq cleared", irq, 1'b0);
        rd(2'd1, v); chk("R8 live after clear", v, 8'h00);

        // R9 modem enable bit and reserved bits
        wr(2'd3, 8'h02); chk("R9 modem_en", modem_en, 1'b1);
        wr(2'd3, 8'hF6); rd(2'd3, v); chk("R9 ctrl readback", v, 8'h02);

        // R10 soft reset pulse
        wr(2'd0, 8'h0F); wr(2'd2, 8'h0F); wr(2'd3, 8'h03);
        wr(2'd3, 8'h08); chk("R10 pulse high", sw_rst_pulse, 1'b1);
        @(negedge clk); chk("R10 pulse one cycle", sw_rst_pulse, 1'b0);
        rd(2'd0, v); chk("R10 dir cleared", v, 8'h00);
        rd(2'd2, v); chk("R10 ien cleared", v, 8'h00);
        rd(2'd3, v); chk("R10 ctrl cleared", v, 8'h00);
        chk("R10 modem/irq", {modem_en, irq}, 2'b00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule